// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is the write state machine behind a small embedded flash array model. Once a command decoder has accepted a request, the sequencer carries out either a byte program or a whole-block erase. A byte program is a train of timed pulses with a verify after each one. A block erase first preconditions every byte to 00h, then applies erase pulses byte by byte, and then verifies each byte. While it runs, the block reports ready, suspended and three sticky error flags, which a status register can mirror.

An erase can be parked at a pulse boundary, so that bytes in other blocks can be read, and later resumed from the byte where it stopped. A low reset/power-down pin, or a program supply that leaves its valid level, stops any operation on the spot and leaves the target partly changed. The program supply arrives as a two-bit level code. Pulse lengths, the pulse limit and the array geometry are parameters. Two defect masks let bits refuse to fall or to rise, so that the verify failures can be provoked.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, ready is 1, suspended and all three error flags are 0, and every byte of the array reads FFh.
- R2: A program sets the target byte to (old AND data), so a program never turns a 0 into a 1. When the first pulse verifies, ready is low for exactly PROG_CYC+1 cycles.
- R3: The program verify fails only when a bit that the data asks to be 0 still reads 1. Data bits of 1 over cells that hold 0 complete without error after one pulse.
- R4: A bit that refuses to fall (its bit is set in stuck1_mask) makes the program retry up to MAX_PULSES pulses. The block then sets err_prog and returns to ready, after MAX_PULSES*(PROG_CYC+1) busy cycles.
- R5: A program or erase started while vpp_lvl is not 01 (00 = low, 10/11 = invalid middle) sets err_vpp, keeps ready at 1 and changes no byte.
- R6: An erase addressed by the block field (upper address bits above the byte offset) leaves all bytes of that block at FFh, leaves other blocks untouched, and keeps ready low for BLOCK_BYTES*(PROG_CYC+ERASE_CYC+1) cycles.
- R7: When a byte fails the erase verify because a bit refuses to rise (its bit is set in stuck0_mask), the erase stops, err_erase is set, and the block returns to ready.
- R8: A suspend request during preconditioning or erase pulses takes effect at the end of the current byte pulse. Suspended and ready are then 1 together. resume_req clears suspended, and the erase continues from the next byte position.
- R9: rp_n low stops any operation at the next edge, leaves bytes already changed as they are, returns ready to 1 and clears all error flags.
- R10: vpp_lvl other than 01 during a running operation stops it at the next edge, sets err_vpp and leaves partial data.
- R11: clr_status while idle clears err_prog, err_erase and err_vpp.
- R12: rd_valid is 0 while an operation runs, and 1 while idle. While suspended, it is 1 only for addresses outside the block being erased. rd_data shows the addressed byte whenever rd_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rp_n | input | 1 | Active-low reset/power-down pin; aborts operations and clears flags |
| vpp_lvl | input | 2 | Program supply level: 00 low, 01 valid high, 10/11 invalid middle |
| start_prog | input | 1 | Start a byte program at cmd_addr with cmd_data (idle only) |
| start_erase | input | 1 | Start an erase of the block that holds cmd_addr (idle only) |
| suspend_req | input | 1 | Request suspension of a running erase |
| resume_req | input | 1 | Resume a suspended erase |
| clr_status | input | 1 | Clear the error flags while idle |
| cmd_addr | input | ADDR_W | Target byte address: block field above byte offset |
| cmd_data | input | 8 | Program data |
| stuck1_mask | input | 8 | Array defect model: these bit positions cannot fall to 0 |
| stuck0_mask | input | 8 | Array defect model: these bit positions cannot rise to 1 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, 00h when rd_valid is 0 |
| rd_valid | output | 1 | Read of rd_addr is permitted |
| ready | output | 1 | Sequencer idle or suspended |
| suspended | output | 1 | Erase is parked |
| err_prog | output | 1 | Sticky program verify failure |
| err_erase | output | 1 | Sticky erase verify failure |
| err_vpp | output | 1 | Sticky program supply fault |

## Verification
The assertions take for granted that start_prog and start_erase are only raised while ready is 1 and suspended is 0. They also assume that at most one of start_prog, start_erase and clr_status is high in a cycle, and that resume_req only comes while suspended. The bench keeps to this: each scenario task raises one command for a single cycle, then waits for ready before it issues the next one. The bench changes the defect masks and vpp_lvl only between operations, except where a scenario provokes an abort on purpose.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PPULSE,
    ST_PVFY,
    ST_EPRE,
    ST_EPULSE,
    ST_EVFY,
    ST_SUSP
  } seq_state_e;

  typedef enum logic [1:0] {
    WR_AND,
    WR_CLEAR,
    WR_SET
  } wr_op_e;

  localparam logic [1:0] VPP_HIGH = 2'b01;

endpackage

// File: rtl/pe_cell_array.sv
module pe_cell_array
  import pe_seq_pkg::*;
#(
  parameter int NUM_BLOCKS  = 16,
  parameter int BLOCK_BYTES = 4,
  localparam int DEPTH      = NUM_BLOCKS * BLOCK_BYTES,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wr_op_e            wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        stuck1_mask,
  input  logic [7:0]        stuck0_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] vfy_addr,
  output logic [7:0]        vfy_data
);

  logic [DEPTH-1:0][7:0] mem_q;
  logic [7:0]            tgt_byte;

  // Target value the current pulse drives towards
  always_comb begin
    unique case (wr_op)
      WR_AND:   tgt_byte = mem_q[wr_addr] & wr_data;
      WR_CLEAR: tgt_byte = 8'h00;
      WR_SET:   tgt_byte = 8'hFF;
      default:  tgt_byte = mem_q[wr_addr];
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] cur;
    logic [7:0] nxt;
    logic       sel;

    assign cur = mem_q[g];
    assign sel = wr_en && (wr_addr == ADDR_W'(g));

    // falling bits blocked by stuck1, rising bits blocked by stuck0
    always_comb begin
      nxt = (cur & tgt_byte)
          | (cur & ~tgt_byte & stuck1_mask)
          | (~cur & tgt_byte & ~stuck0_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= 8'hFF;
      end else if (sel) begin
        mem_q[g] <= nxt;
      end
    end
  end

  assign rd_data  = mem_q[rd_addr];
  assign vfy_data = mem_q[vfy_addr];

endmodule

// File: rtl/pe_pulse_timer.sv
module pe_pulse_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pe_seq_ctrl.sv
module pe_seq_ctrl
  import pe_seq_pkg::*;
#(
  parameter int NUM_BLOCKS  = 16,
  parameter int BLOCK_BYTES = 4,
  parameter int PROG_CYC    = 3,
  parameter int ERASE_CYC   = 5,
  parameter int MAX_PULSES  = 3,
  localparam int ADDR_W     = $clog2(NUM_BLOCKS * BLOCK_BYTES),
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = ADDR_W - OFF_W,
  localparam int CNT_W      = $clog2(((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) + 1),
  localparam int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic [1:0]        vpp_lvl,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              clr_status,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [7:0]        vfy_data,
  input  logic              tmr_done,
  output logic              tmr_start,
  output logic [CNT_W-1:0]  tmr_load,
  output logic              wr_en,
  output wr_op_e            wr_op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [7:0]        cur_data,
  output logic [BLK_W-1:0]  act_blk,
  output logic              ready,
  output logic              suspended,
  output logic              err_prog,
  output logic              err_erase,
  output logic              err_vpp
);

  seq_state_e        state_q, state_d;
  seq_state_e        resume_q, resume_d;
  seq_state_e        step_st;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [PC_W-1:0]   pcnt_q, pcnt_d;
  logic              pend_q, pend_d;
  logic              ep_q, ep_d, ee_q, ee_d, ev_q, ev_d;
  logic              op_active;
  logic              last_byte;
  logic [OFF_W-1:0]  cur_off;
  logic [BLK_W-1:0]  cur_blk;
  logic [ADDR_W-1:0] next_addr;

  assign cur_off   = addr_q[OFF_W-1:0];
  assign cur_blk   = addr_q[ADDR_W-1:OFF_W];
  assign last_byte = (cur_off == OFF_W'(BLOCK_BYTES - 1));
  assign next_addr = {cur_blk, cur_off + OFF_W'(1)};

  assign op_active = (state_q == ST_PPULSE) || (state_q == ST_PVFY) ||
                     (state_q == ST_EPRE)   || (state_q == ST_EPULSE) ||
                     (state_q == ST_EVFY);

  // Phase that follows the current byte pulse within an erase
  always_comb begin
    if (state_q == ST_EPRE) begin
      step_st = last_byte ? ST_EPULSE : ST_EPRE;
    end else begin
      step_st = last_byte ? ST_EVFY : ST_EPULSE;
    end
  end

  always_comb begin
    state_d   = state_q;
    resume_d  = resume_q;
    addr_d    = addr_q;
    data_d    = data_q;
    pcnt_d    = pcnt_q;
    pend_d    = pend_q;
    ep_d      = ep_q;
    ee_d      = ee_q;
    ev_d      = ev_q;
    wr_en     = 1'b0;
    wr_op     = WR_AND;
    tmr_start = 1'b0;
    tmr_load  = CNT_W'(PROG_CYC);

    if (!rp_n) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      ep_d    = 1'b0;
      ee_d    = 1'b0;
      ev_d    = 1'b0;
    end else if (op_active && (vpp_lvl != VPP_HIGH)) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      ev_d    = 1'b1;
    end else begin
      if (suspend_req && ((state_q == ST_EPRE) || (state_q == ST_EPULSE))) begin
        pend_d = 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          pend_d = 1'b0;
          if (start_prog) begin
            if (vpp_lvl != VPP_HIGH) begin
              ev_d = 1'b1;
            end else begin
              addr_d    = cmd_addr;
              data_d    = cmd_data;
              pcnt_d    = PC_W'(1);
              state_d   = ST_PPULSE;
              tmr_start = 1'b1;
            end
          end else if (start_erase) begin
            if (vpp_lvl != VPP_HIGH) begin
              ev_d = 1'b1;
            end else begin
              addr_d    = {cmd_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
              state_d   = ST_EPRE;
              tmr_start = 1'b1;
            end
          end else if (clr_status) begin
            ep_d = 1'b0;
            ee_d = 1'b0;
            ev_d = 1'b0;
          end
        end
        ST_PPULSE: begin
          if (tmr_done) begin
            wr_en   = 1'b1;
            wr_op   = WR_AND;
            state_d = ST_PVFY;
          end
        end
        ST_PVFY: begin
          if ((vfy_data & ~data_q) == 8'h00) begin
            state_d = ST_IDLE;
          end else if (pcnt_q == PC_W'(MAX_PULSES)) begin
            ep_d    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            pcnt_d    = pcnt_q + PC_W'(1);
            state_d   = ST_PPULSE;
            tmr_start = 1'b1;
          end
        end
        ST_EPRE, ST_EPULSE: begin
          if (tmr_done) begin
            wr_en  = 1'b1;
            wr_op  = (state_q == ST_EPRE) ? WR_CLEAR : WR_SET;
            addr_d = next_addr;
            if (pend_d) begin
              resume_d = step_st;
              state_d  = ST_SUSP;
              pend_d   = 1'b0;
            end else begin
              state_d   = step_st;
              tmr_start = (step_st != ST_EVFY);
              tmr_load  = (step_st == ST_EPULSE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
            end
          end
        end
        ST_EVFY: begin
          if (vfy_data != 8'hFF) begin
            ee_d    = 1'b1;
            state_d = ST_IDLE;
          end else if (last_byte) begin
            state_d = ST_IDLE;
          end else begin
            addr_d = next_addr;
          end
        end
        ST_SUSP: begin
          if (resume_req) begin
            state_d   = resume_q;
            tmr_start = (resume_q != ST_EVFY);
            tmr_load  = (resume_q == ST_EPULSE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      resume_q <= ST_EPRE;
      addr_q   <= '0;
      data_q   <= '0;
      pcnt_q   <= '0;
      pend_q   <= 1'b0;
      ep_q     <= 1'b0;
      ee_q     <= 1'b0;
      ev_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      pcnt_q   <= pcnt_d;
      pend_q   <= pend_d;
      ep_q     <= ep_d;
      ee_q     <= ee_d;
      ev_q     <= ev_d;
    end
  end

  assign cur_addr  = addr_q;
  assign cur_data  = data_q;
  assign act_blk   = cur_blk;
  assign ready     = (state_q == ST_IDLE) || (state_q == ST_SUSP);
  assign suspended = (state_q == ST_SUSP);
  assign err_prog  = ep_q;
  assign err_erase = ee_q;
  assign err_vpp   = ev_q;

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_seq_pkg::*;
#(
  parameter int NUM_BLOCKS  = 16,
  parameter int BLOCK_BYTES = 4,
  parameter int PROG_CYC    = 3,
  parameter int ERASE_CYC   = 5,
  parameter int MAX_PULSES  = 3,
  localparam int ADDR_W     = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic [1:0]        vpp_lvl,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              clr_status,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [7:0]        stuck1_mask,
  input  logic [7:0]        stuck0_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              ready,
  output logic              suspended,
  output logic              err_prog,
  output logic              err_erase,
  output logic              err_vpp
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              tmr_start;
  logic              tmr_done;
  logic [CNT_W-1:0]  tmr_load;
  logic              wr_en;
  wr_op_e            wr_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_data;
  logic [7:0]        vfy_data;
  logic [7:0]        arr_rd;
  logic [BLK_W-1:0]  act_blk;
  logic [BLK_W-1:0]  rd_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  pe_seq_ctrl #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_BYTES(BLOCK_BYTES),
    .PROG_CYC   (PROG_CYC),
    .ERASE_CYC  (ERASE_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rp_n       (rp_n),
    .vpp_lvl    (vpp_lvl),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .suspend_req(suspend_req),
    .resume_req (resume_req),
    .clr_status (clr_status),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .vfy_data   (vfy_data),
    .tmr_done   (tmr_done),
    .tmr_start  (tmr_start),
    .tmr_load   (tmr_load),
    .wr_en      (wr_en),
    .wr_op      (wr_op),
    .cur_addr   (cur_addr),
    .cur_data   (cur_data),
    .act_blk    (act_blk),
    .ready      (ready),
    .suspended  (suspended),
    .err_prog   (err_prog),
    .err_erase  (err_erase),
    .err_vpp    (err_vpp)
  );

  pe_pulse_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (tmr_start),
    .load_val(tmr_load),
    .done    (tmr_done)
  );

  pe_cell_array #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_op      (wr_op),
    .wr_addr    (cur_addr),
    .wr_data    (cur_data),
    .stuck1_mask(stuck1_mask),
    .stuck0_mask(stuck0_mask),
    .rd_addr    (rd_addr),
    .rd_data    (arr_rd),
    .vfy_addr   (cur_addr),
    .vfy_data   (vfy_data)
  );

  assign rd_blk   = rd_addr[ADDR_W-1:OFF_W];
  assign rd_valid = suspended ? (rd_blk != act_blk) : ready;
  assign rd_data  = rd_valid ? arr_rd : 8'h00;

endmodule

// File: rtl/pe_sequencer_chk.sv
module pe_sequencer_chk
  import pe_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rp_n,
  input logic [1:0] vpp_lvl,
  input logic       start_prog,
  input logic       start_erase,
  input logic       resume_req,
  input logic       clr_status,
  input logic       rd_valid,
  input logic       ready,
  input logic       suspended,
  input logic       err_prog,
  input logic       err_erase,
  input logic       err_vpp
);

  a_r8_susp_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> ready);

  a_r8_resume_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended) |-> ($past(resume_req) || !$past(rp_n)));

  a_r12_busy_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !rd_valid);

  a_r5_start_bad_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !suspended && rp_n && (start_prog || start_erase) && (vpp_lvl != VPP_HIGH))
    |=> (err_vpp && ready));

  a_r9_rp_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (ready && !suspended && !err_prog && !err_erase && !err_vpp));

  a_r10_vpp_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && rp_n && (vpp_lvl != VPP_HIGH)) |=> (ready && err_vpp));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !suspended && rp_n && clr_status && !start_prog && !start_erase)
    |=> (!err_prog && !err_erase && !err_vpp));

  a_r4_prog_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_prog) |-> (ready && !suspended));

  a_r7_erase_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_erase) |-> (ready && !suspended));

endmodule

bind pe_sequencer pe_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rp_n       (rp_n),
  .vpp_lvl    (vpp_lvl),
  .start_prog (start_prog),
  .start_erase(start_erase),
  .resume_req (resume_req),
  .clr_status (clr_status),
  .rd_valid   (rd_valid),
  .ready      (ready),
  .suspended  (suspended),
  .err_prog   (err_prog),
  .err_erase  (err_erase),
  .err_vpp    (err_vpp)
);

// File: tb/pe_sequencer_test.sv
`timescale 1ns/1ps
module pe_sequencer_test;

  localparam int NB   = 16;
  localparam int BB   = 4;
  localparam int PC   = 3;
  localparam int EC   = 5;
  localparam int MP   = 3;
  localparam int AW   = $clog2(NB * BB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rp_n;
  logic [1:0]    vpp_lvl;
  logic          start_prog, start_erase, suspend_req, resume_req, clr_status;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0]    cmd_data, stuck1_mask, stuck0_mask;
  logic [7:0]    rd_data;
  logic          rd_valid, ready, suspended, err_prog, err_erase, err_vpp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pe_sequencer #(
    .NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .PROG_CYC(PC), .ERASE_CYC(EC), .MAX_PULSES(MP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_lvl(vpp_lvl),
    .start_prog(start_prog), .start_erase(start_erase),
    .suspend_req(suspend_req), .resume_req(resume_req), .clr_status(clr_status),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .stuck1_mask(stuck1_mask), .stuck0_mask(stuck0_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .ready(ready), .suspended(suspended),
    .err_prog(err_prog), .err_erase(err_erase), .err_vpp(err_vpp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic v);
    rd_addr = a;
    #1;
    d = rd_data;
    v = rd_valid;
  endtask

  task automatic wait_ready(output int busy);
    busy = 0;
    while (!ready && busy < 2000) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, output int busy);
    @(negedge clk);
    cmd_addr = a; cmd_data = d; start_prog = 1'b1;
    @(negedge clk);
    start_prog = 1'b0;
    wait_ready(busy);
  endtask

  task automatic do_erase(input logic [AW-1:0] a, output int busy);
    @(negedge clk);
    cmd_addr = a; start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0;
    wait_ready(busy);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v; bit all_ff = 1'b1;
    check(ready && !suspended, "R1", "ready after reset", {ready, suspended}, 2'b10);
    check(!err_prog && !err_erase && !err_vpp, "R1", "flags after reset",
          {err_prog, err_erase, err_vpp}, 0);
    for (int i = 0; i < NB * BB; i++) begin
      rd(AW'(i), d, v);
      if (d != 8'hFF || !v) all_ff = 1'b0;
    end
    check(all_ff, "R1", "array erased after reset", all_ff, 1);
  endtask

  task automatic t_program();
    int busy; logic [7:0] d; logic v;
    @(negedge clk);
    cmd_addr = 6'h05; cmd_data = 8'hA5; start_prog = 1'b1;
    @(negedge clk);
    start_prog = 1'b0;
    rd(6'h20, d, v);
    check(!v && !ready, "R12", "rd_valid while programming", v, 0);
    wait_ready(busy);
    check(busy == PC + 1, "R2", "busy cycles one pulse", busy, PC + 1);
    rd(6'h05, d, v);
    check(d == 8'hA5, "R2", "programmed byte", d, 8'hA5);
    do_prog(6'h05, 8'h0F, busy);
    rd(6'h05, d, v);
    check(d == 8'h05, "R2", "AND of old and data", d, 8'h05);
    do_prog(6'h05, 8'hFF, busy);
    rd(6'h05, d, v);
    check(d == 8'h05 && !err_prog, "R3", "ones over zeros no error", {err_prog, d}, 8'h05);
    check(busy == PC + 1, "R3", "one pulse for ones over zeros", busy, PC + 1);
  endtask

  task automatic t_prog_stuck();
    int busy; logic [7:0] d; logic v;
    stuck1_mask = 8'h01;
    do_prog(6'h08, 8'hFE, busy);
    check(err_prog, "R4", "err_prog after pulse limit", err_prog, 1);
    check(busy == MP * (PC + 1), "R4", "busy cycles at pulse limit", busy, MP * (PC + 1));
    rd(6'h08, d, v);
    check(d == 8'hFF, "R4", "stuck bit kept", d, 8'hFF);
    stuck1_mask = 8'h00;
    do_clear();
    check(!err_prog && !err_erase && !err_vpp, "R11", "clear after program error",
          {err_prog, err_erase, err_vpp}, 0);
  endtask

  task automatic t_vpp_start();
    logic [7:0] d; logic v;
    vpp_lvl = 2'b00;
    @(negedge clk);
    cmd_addr = 6'h10; cmd_data = 8'h00; start_prog = 1'b1;
    @(negedge clk);
    start_prog = 1'b0;
    check(err_vpp && ready, "R5", "program with low supply", {err_vpp, ready}, 2'b11);
    rd(6'h10, d, v);
    check(d == 8'hFF, "R5", "byte unchanged on low supply", d, 8'hFF);
    do_clear();
    vpp_lvl = 2'b10;
    @(negedge clk);
    cmd_addr = 6'h10; start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0;
    check(err_vpp && ready, "R5", "erase with middle supply", {err_vpp, ready}, 2'b11);
    vpp_lvl = 2'b01;
    do_clear();
    check(!err_vpp, "R11", "clear vpp error", err_vpp, 0);
  endtask

  task automatic t_erase();
    int busy; logic [7:0] d; logic v; bit ok = 1'b1;
    do_prog(6'h03, 8'h3C, busy);
    do_prog(6'h06, 8'h00, busy);
    do_erase(6'h06, busy);
    check(busy == BB * (PC + EC + 1), "R6", "erase busy cycles", busy, BB * (PC + EC + 1));
    for (int i = 4; i < 8; i++) begin
      rd(AW'(i), d, v);
      if (d != 8'hFF) ok = 1'b0;
    end
    check(ok && !err_erase, "R6", "block erased", ok, 1);
    rd(6'h03, d, v);
    check(d == 8'h3C, "R6", "other block untouched", d, 8'h3C);
  endtask

  task automatic t_erase_fail();
    int busy; logic [7:0] d; logic v;
    stuck0_mask = 8'h80;
    do_erase(6'h0C, busy);
    check(err_erase, "R7", "erase verify failure flag", err_erase, 1);
    check(busy == BB * (PC + EC) + 1, "R7", "stops at first bad byte", busy, BB * (PC + EC) + 1);
    rd(6'h0C, d, v);
    check(d == 8'h7F, "R7", "bit could not rise", d, 8'h7F);
    stuck0_mask = 8'h00;
    do_clear();
  endtask

  task automatic t_suspend();
    int busy; int cnt; logic [7:0] d; logic v; bit ok = 1'b1;
    do_prog(6'h09, 8'h55, busy);
    @(negedge clk);
    cmd_addr = 6'h08; start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0; suspend_req = 1'b1;
    @(negedge clk);
    suspend_req = 1'b0;
    cnt = 0;
    while (!suspended && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 2, "R8", "suspend at pulse boundary", cnt, 2);
    check(ready && suspended, "R8", "ready with suspended", {ready, suspended}, 2'b11);
    rd(6'h03, d, v);
    check(v && d == 8'h3C, "R12", "read other block while suspended", {v, d}, 9'h13C);
    rd(6'h09, d, v);
    check(!v, "R12", "read erased block blocked", v, 0);
    @(negedge clk);
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
    check(!suspended && !ready, "R8", "resume clears suspended", {ready, suspended}, 0);
    wait_ready(busy);
    check(busy == (BB - 1) * PC + BB * (EC + 1), "R8", "resume from saved byte",
          busy, (BB - 1) * PC + BB * (EC + 1));
    for (int i = 8; i < 12; i++) begin
      rd(AW'(i), d, v);
      if (d != 8'hFF) ok = 1'b0;
    end
    check(ok && !err_erase, "R8", "block erased after resume", ok, 1);
  endtask

  task automatic t_rp_abort();
    int busy; logic [7:0] d; logic v; bit ok = 1'b1;
    stuck1_mask = 8'h01;
    do_prog(6'h30, 8'hFE, busy);
    stuck1_mask = 8'h00;
    @(negedge clk);
    cmd_addr = 6'h10; start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0;
    repeat (13) @(negedge clk);
    rp_n = 1'b0;
    @(negedge clk);
    check(ready && !err_prog, "R9", "reset pin aborts and clears", {ready, err_prog}, 2'b10);
    rp_n = 1'b1;
    for (int i = 16; i < 20; i++) begin
      rd(AW'(i), d, v);
      if (d != 8'h00) ok = 1'b0;
    end
    check(ok, "R9", "block left preconditioned", ok, 1);
    rd(6'h14, d, v);
    check(d == 8'hFF, "R9", "next block untouched", d, 8'hFF);
  endtask

  task automatic t_vpp_abort();
    logic [7:0] d; logic v; bit ok = 1'b1;
    @(negedge clk);
    cmd_addr = 6'h2C; cmd_data = 8'h00; start_prog = 1'b1;
    @(negedge clk);
    start_prog = 1'b0; vpp_lvl = 2'b10;
    @(negedge clk);
    check(ready && err_vpp, "R10", "middle supply aborts program", {ready, err_vpp}, 2'b11);
    rd(6'h2C, d, v);
    check(d == 8'hFF, "R10", "byte not yet written", d, 8'hFF);
    vpp_lvl = 2'b01;
    do_clear();
    @(negedge clk);
    cmd_addr = 6'h14; start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0;
    repeat (13) @(negedge clk);
    vpp_lvl = 2'b00;
    @(negedge clk);
    check(ready && err_vpp, "R10", "low supply aborts erase", {ready, err_vpp}, 2'b11);
    vpp_lvl = 2'b01;
    for (int i = 20; i < 24; i++) begin
      rd(AW'(i), d, v);
      if (d != 8'h00) ok = 1'b0;
    end
    check(ok, "R10", "partial erase left", ok, 1);
    do_clear();
    check(!err_vpp, "R11", "clear after abort", err_vpp, 0);
  endtask

  initial begin
    rst_n = 1'b0; rp_n = 1'b1; vpp_lvl = 2'b01;
    start_prog = 1'b0; start_erase = 1'b0; suspend_req = 1'b0;
    resume_req = 1'b0; clr_status = 1'b0;
    cmd_addr = '0; cmd_data = '0; rd_addr = '0;
    stuck1_mask = 8'h00; stuck0_mask = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_prog_stuck();
    t_vpp_start();
    t_erase();
    t_erase_fail();
    t_suspend();
    t_rp_abort();
    t_vpp_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule